// File: doc/BRIEF.md
# Unrolled Pipelined SHA-256 Compression Core

This block computes the SHA-256 compression of one 512-bit message chunk per clock. Each cycle the source may present a chunk that has already been padded, together with the eight-word chaining value it should be folded into, and mark the pair with a valid bit. The 64 rounds are laid out one after another, each with its own register stage. The message schedule moves through the pipeline beside the round state, so every stage has the 32-bit schedule word it needs.

The result is the eight-word sum of the chaining value and the state after round 64. It leaves through one more register stage with its own valid bit. Results come out in the order the chunks went in, one per cycle, after a fixed fill latency. There is no flow control and the pipeline never stalls. Padding and linking chunks into a multi-block message are left to the surrounding logic, which feeds each digest back as the next chaining value.

Top module: `sha256_unrolled`

## Requirements
- R1: While reset is held and afterwards with no valid input, `out_valid` stays 0.
- R2: For each accepted chunk, `out_digest` equals the SHA-256 compression of `in_block` into `in_chain`, with the chaining value added word by word modulo 2^32. Message word 0 is `in_block[511:480]`. Chaining word 0 (the a word) is `in_chain[255:224]`. Digest word 0 is `out_digest[255:224]`.
- R3: A chunk sampled with `in_valid` = 1 on rising edge n yields `out_valid` = 1 and its digest after rising edge n+64, and not after any earlier edge.
- R4: Chunks presented on consecutive cycles produce digests on consecutive cycles, in input order.
- R5: A cycle with `in_valid` = 0 produces a cycle with `out_valid` = 0 64 edges later. The contents of `in_block` and `in_chain` in that cycle affect no digest.
- R6: Any chaining value is accepted; the result is not tied to the standard initial hash value.
- R7: Schedule words 0 to 15 are the chunk words in order. Words 16 to 63 are the four-operand sum of the two sigma-mixed words and the words 7 and 16 places back. Each stage hands the next stage its window shifted down by one word.
- R8: In each round the new b, c, d, f, g and h words are the previous a, b, c, e, f and g words.
- R9: Bit 0 of each new e word equals the XOR of d0, h0, e6, e11, e25, bit 0 of the round constant, bit 0 of the schedule word, e0&f0 and ~e0&g0 of the previous state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Marks `in_block`/`in_chain` as a chunk to hash this cycle |
| in_block | input | 512 | Padded chunk, word 0 in the top 32 bits |
| in_chain | input | 256 | Chaining value, a word in the top 32 bits |
| out_valid | output | 1 | Marks `out_digest` as a finished result |
| out_digest | output | 256 | Chaining value plus final round state, word 0 in the top 32 bits |

## Verification
The assertions assume `in_valid` is a defined 0 or 1 on every edge after reset. Data registers only load on valid cycles, so the hold and round checks trust the data path only behind a valid bit. The stimulus holds `in_valid` to a defined level from time zero and changes every input on the falling edge. On idle cycles it fills the data buses with random values, so that a chunk's result would show any stray capture.

// File: rtl/sha_pipe_pkg.sv
package sha_pipe_pkg;

  localparam int WORD_W    = 32;
  localparam int ROUNDS    = 64;
  localparam int WIN_WORDS = 16;
  localparam int N_STATE   = 8;
  localparam int HASH_W    = WORD_W * N_STATE;
  localparam int BLOCK_W   = WORD_W * WIN_WORDS;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    word_t a;
    word_t b;
    word_t c;
    word_t d;
    word_t e;
    word_t f;
    word_t g;
    word_t h;
  } hstate_t;

  localparam word_t K_TAB [ROUNDS] = '{
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5,
    32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3,
    32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc,
    32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7,
    32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13,
    32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3,
    32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5,
    32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208,
    32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
  };

  function automatic word_t rotr(input word_t x, input int unsigned n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t big_sig0(input word_t x);
    return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
  endfunction

  function automatic word_t big_sig1(input word_t x);
    return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
  endfunction

  function automatic word_t small_sig0(input word_t x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  function automatic word_t small_sig1(input word_t x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction

  function automatic word_t f_choose(input word_t x, input word_t y, input word_t z);
    return (x & y) ^ (~x & z);
  endfunction

  function automatic word_t f_major(input word_t x, input word_t y, input word_t z);
    return (x & y) ^ (x & z) ^ (y & z);
  endfunction

endpackage

// File: rtl/sha_rst_sync.sv
module sha_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/sha_sched_step.sv
module sha_sched_step
  import sha_pipe_pkg::*;
(
  input  word_t w_back2_i,
  input  word_t w_back7_i,
  input  word_t w_back15_i,
  input  word_t w_back16_i,
  output word_t w_o
);

  // R7: four-operand sum of the mixed and plain earlier words
  always_comb begin
    w_o = small_sig1(w_back2_i) + w_back7_i + small_sig0(w_back15_i) + w_back16_i;
  end

endmodule

// File: rtl/sha_round_stage.sv
module sha_round_stage
  import sha_pipe_pkg::*;
#(
  parameter int IDX      = 0,
  parameter int LIVE_IN  = WIN_WORDS,
  parameter int LIVE_OUT = WIN_WORDS
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      v_i,
  input  hstate_t                   st_i,
  input  logic [HASH_W-1:0]         cv_i,
  input  logic [WORD_W*LIVE_IN-1:0] win_i,
  output logic                      v_o,
  output hstate_t                   st_o,
  output logic [HASH_W-1:0]         cv_o,
  output logic [BLOCK_W-1:0]        win_o
);

  localparam word_t K_RND = K_TAB[IDX];

  word_t   w_cur;
  word_t   t1;
  word_t   t2;
  hstate_t st_d;
  logic    e0_pred;

  assign w_cur = win_i[WORD_W-1:0];

  // next-state: one compression round
  always_comb begin
    t1      = st_i.h + big_sig1(st_i.e) + f_choose(st_i.e, st_i.f, st_i.g) + K_RND + w_cur;
    t2      = big_sig0(st_i.a) + f_major(st_i.a, st_i.b, st_i.c);
    st_d.a  = t1 + t2;
    st_d.b  = st_i.a;
    st_d.c  = st_i.b;
    st_d.d  = st_i.c;
    st_d.e  = st_i.d + t1;
    st_d.f  = st_i.e;
    st_d.g  = st_i.f;
    st_d.h  = st_i.g;
  end

  // carry-free prediction of the new e word's bit 0
  always_comb begin
    e0_pred = st_i.d[0] ^ st_i.h[0] ^ st_i.e[6] ^ st_i.e[11] ^ st_i.e[25]
            ^ K_RND[0] ^ w_cur[0]
            ^ (st_i.e[0] & st_i.f[0]) ^ (~st_i.e[0] & st_i.g[0]);
  end

  logic              v_q;
  hstate_t           st_q;
  logic [HASH_W-1:0] cv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= 1'b0;
    else        v_q <= v_i;
  end

  always_ff @(posedge clk) begin
    if (v_i) begin
      st_q <= st_d;
      cv_q <= cv_i;
    end
  end

  assign v_o  = v_q;
  assign st_o = st_q;
  assign cv_o = cv_q;

  // schedule window: word 0 is consumed here, the rest shift down
  for (genvar j = 0; j < WIN_WORDS; j++) begin : g_win
    if (j < LIVE_OUT) begin : g_live
      word_t w_d;
      word_t w_q;
      if (j + 1 < LIVE_IN) begin : g_shift
        assign w_d = win_i[WORD_W*(j+1) +: WORD_W];
      end else begin : g_fresh
        sha_sched_step u_step (
          .w_back2_i  (win_i[WORD_W*14 +: WORD_W]),
          .w_back7_i  (win_i[WORD_W*9  +: WORD_W]),
          .w_back15_i (win_i[WORD_W*1  +: WORD_W]),
          .w_back16_i (win_i[WORD_W*0  +: WORD_W]),
          .w_o        (w_d)
        );
      end
      always_ff @(posedge clk) begin
        if (v_i) w_q <= w_d;
      end
      assign win_o[WORD_W*j +: WORD_W] = w_q;
    end else begin : g_dead
      assign win_o[WORD_W*j +: WORD_W] = '0;
    end
  end

  // R9: new e bit 0 matches the nine-term parity of the previous state
  a_r9_e_bit0: assert property (@(posedge clk) disable iff (!rst_n)
    v_i |=> (st_o.e[0] == $past(e0_pred)));

  // R8: six of the eight words are a repositioning of the previous state
  a_r8_reposition: assert property (@(posedge clk) disable iff (!rst_n)
    v_i |=> (st_o.b == $past(st_i.a)) && (st_o.c == $past(st_i.b)) &&
            (st_o.d == $past(st_i.c)) && (st_o.f == $past(st_i.e)) &&
            (st_o.g == $past(st_i.f)) && (st_o.h == $past(st_i.g)));

  // R5: an idle slot leaves the stage data untouched
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !v_i |=> $stable(st_o) && $stable(cv_o));

  if (LIVE_OUT > 0 && LIVE_IN > 1) begin : g_win_chk
    // R7: the next stage sees this stage's window moved down one word
    a_r7_window_shift: assert property (@(posedge clk) disable iff (!rst_n)
      v_i |=> (win_o[WORD_W-1:0] == $past(win_i[2*WORD_W-1:WORD_W])));
  end

endmodule

// File: rtl/sha_digest_add.sv
module sha_digest_add
  import sha_pipe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              v_i,
  input  hstate_t           st_i,
  input  logic [HASH_W-1:0] cv_i,
  output logic              v_o,
  output logic [HASH_W-1:0] dig_o
);

  logic [HASH_W-1:0] st_vec;
  logic [HASH_W-1:0] dig_d;
  logic [HASH_W-1:0] dig_q;
  logic              v_q;

  assign st_vec = st_i;

  for (genvar w = 0; w < N_STATE; w++) begin : g_word
    assign dig_d[WORD_W*w +: WORD_W] = st_vec[WORD_W*w +: WORD_W] + cv_i[WORD_W*w +: WORD_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= 1'b0;
    else        v_q <= v_i;
  end

  always_ff @(posedge clk) begin
    if (v_i) dig_q <= dig_d;
  end

  assign v_o   = v_q;
  assign dig_o = dig_q;

  // R3: the last stage's valid reaches the output one edge later
  a_r3_out_follow: assert property (@(posedge clk) disable iff (!rst_n)
    v_i |=> v_o);

  // R5: an empty slot stays empty at the output
  a_r5_out_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !v_i |=> !v_o && $stable(dig_o));

endmodule

// File: rtl/sha256_unrolled.sv
module sha256_unrolled
  import sha_pipe_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [BLOCK_W-1:0] in_block,
  input  logic [HASH_W-1:0]  in_chain,
  output logic               out_valid,
  output logic [HASH_W-1:0]  out_digest
);

  logic rst_q_n;

  sha_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  logic              v_bus   [ROUNDS+1];
  hstate_t           st_bus  [ROUNDS+1];
  logic [HASH_W-1:0] cv_bus  [ROUNDS+1];
  logic [BLOCK_W-1:0] win_bus [ROUNDS+1];

  assign v_bus[0]  = in_valid;
  assign st_bus[0] = hstate_t'(in_chain);
  assign cv_bus[0] = in_chain;

  // chunk word 0 (top bits) becomes window word 0 (low bits)
  for (genvar j = 0; j < WIN_WORDS; j++) begin : g_in_word
    assign win_bus[0][WORD_W*j +: WORD_W] = in_block[BLOCK_W-1-WORD_W*j -: WORD_W];
  end

  for (genvar i = 0; i < ROUNDS; i++) begin : g_round
    localparam int LIN  = (ROUNDS - i < WIN_WORDS) ? ROUNDS - i : WIN_WORDS;
    localparam int LOUT = (ROUNDS - 1 - i < WIN_WORDS) ? ROUNDS - 1 - i : WIN_WORDS;
    sha_round_stage #(
      .IDX      (i),
      .LIVE_IN  (LIN),
      .LIVE_OUT (LOUT)
    ) u_stage (
      .clk   (clk),
      .rst_n (rst_q_n),
      .v_i   (v_bus[i]),
      .st_i  (st_bus[i]),
      .cv_i  (cv_bus[i]),
      .win_i (win_bus[i][WORD_W*LIN-1:0]),
      .v_o   (v_bus[i+1]),
      .st_o  (st_bus[i+1]),
      .cv_o  (cv_bus[i+1]),
      .win_o (win_bus[i+1])
    );
  end

  sha_digest_add u_digest (
    .clk   (clk),
    .rst_n (rst_q_n),
    .v_i   (v_bus[ROUNDS]),
    .st_i  (st_bus[ROUNDS]),
    .cv_i  (cv_bus[ROUNDS]),
    .v_o   (out_valid),
    .dig_o (out_digest)
  );

  // R1: nothing leaves the pipeline while reset is applied
  a_r1_reset_quiet: assert property (@(posedge clk) !rst_q_n |-> !out_valid);

endmodule

// File: tb/test_sha256_unrolled.sv
module test_sha256_unrolled;

  localparam int LAT = 64;

  typedef struct packed {
    logic [511:0] blk;
    logic [255:0] cv;
    logic [255:0] dig;
  } vec_t;

  localparam logic [255:0] IV =
    256'h6a09e667_bb67ae85_3c6ef372_a54ff53a_510e527f_9b05688c_1f83d9ab_5be0cd19;

  localparam vec_t VECS [2] = '{
    '{blk: {32'h61626380, 416'h0, 32'h0, 32'h00000018}, cv: IV,
      dig: 256'hba7816bf_8f01cfea_414140de_5dae2223_b00361a3_96177a9c_b410ff61_f20015ad},
    '{blk: {32'h80000000, 480'h0}, cv: IV,
      dig: 256'he3b0c442_98fc1c14_9afbf4c8_996fb924_27ae41e4_649b934c_a495991b_7852b855}
  };

  localparam logic [31:0] KREF [64] = '{
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [511:0] in_block = '0;
  logic [255:0] in_chain = '0;
  logic         out_valid;
  logic [255:0] out_digest;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit mon_on = 1'b0;

  always #10 clk = ~clk;

  sha256_unrolled i_sha256_unrolled (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_block   (in_block),
    .in_chain   (in_chain),
    .out_valid  (out_valid),
    .out_digest (out_digest)
  );

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [255:0] ref_hash(input logic [255:0] cv, input logic [511:0] blk);
    logic [31:0] w [64];
    logic [31:0] s [8];
    logic [31:0] t1, t2;
    for (int t = 0; t < 16; t++) w[t] = blk[511-32*t -: 32];
    for (int t = 16; t < 64; t++)
      w[t] = (rr(w[t-2], 17) ^ rr(w[t-2], 19) ^ (w[t-2] >> 10)) + w[t-7]
           + (rr(w[t-15], 7) ^ rr(w[t-15], 18) ^ (w[t-15] >> 3)) + w[t-16];
    for (int k = 0; k < 8; k++) s[k] = cv[255-32*k -: 32];
    for (int t = 0; t < 64; t++) begin
      t1 = s[7] + (rr(s[4], 6) ^ rr(s[4], 11) ^ rr(s[4], 25))
         + ((s[4] & s[5]) ^ (~s[4] & s[6])) + KREF[t] + w[t];
      t2 = (rr(s[0], 2) ^ rr(s[0], 13) ^ rr(s[0], 22))
         + ((s[0] & s[1]) ^ (s[0] & s[2]) ^ (s[1] & s[2]));
      s[7] = s[6]; s[6] = s[5]; s[5] = s[4]; s[4] = s[3] + t1;
      s[3] = s[2]; s[2] = s[1]; s[1] = s[0]; s[0] = t1 + t2;
    end
    for (int k = 0; k < 8; k++) ref_hash[255-32*k -: 32] = s[k] + cv[255-32*k -: 32];
  endfunction

  function automatic logic [511:0] rnd_blk();
    logic [511:0] r;
    for (int k = 0; k < 16; k++) r[32*k +: 32] = $urandom;
    return r;
  endfunction

  function automatic logic [255:0] rnd_cv();
    logic [255:0] r;
    for (int k = 0; k < 8; k++) r[32*k +: 32] = $urandom;
    return r;
  endfunction

  // expectation line, advanced on the same edges as the design
  logic         drv_v = 1'b0;
  logic [255:0] drv_d = '0;
  string        drv_tag = "R1";
  logic         exp_v [LAT+1];
  logic [255:0] exp_d [LAT+1];
  string        exp_tag [LAT+1];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k <= LAT; k++) begin
        exp_v[k] <= 1'b0; exp_d[k] <= '0; exp_tag[k] <= "R1";
      end
    end else begin
      for (int k = LAT; k > 0; k--) begin
        exp_v[k] <= exp_v[k-1]; exp_d[k] <= exp_d[k-1]; exp_tag[k] <= exp_tag[k-1];
      end
      exp_v[0] <= drv_v; exp_d[0] <= drv_d; exp_tag[0] <= drv_tag;
    end
  end

  // R3: an input sampled on edge n is compared after edge n+64
  always @(negedge clk) begin
    if (mon_on && !done && (exp_v[LAT] || out_valid)) begin
      checks++;
      if (out_valid !== exp_v[LAT] || (exp_v[LAT] && out_digest !== exp_d[LAT])) begin
        fails++;
        $display("FAIL %s: out_valid=%0b digest=%h expected out_valid=%0b digest=%h",
                 exp_tag[LAT], out_valid, out_digest, exp_v[LAT], exp_d[LAT]);
      end
    end
  end

  task automatic push(input logic v, input logic [511:0] b, input logic [255:0] c, input string tag);
    @(negedge clk);
    in_valid = v; in_block = b; in_chain = c;
    drv_v = v; drv_d = v ? ref_hash(c, b) : '0; drv_tag = tag;
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) push(1'b0, rnd_blk(), rnd_cv(), tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: output quiet during reset
    checks++;
    if (out_valid !== 1'b0) begin
      fails++; $display("FAIL R1: out_valid=%0b expected 0 in reset", out_valid);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1'b1;
    idle(LAT + 4, "R1");
    checks++;
    if (out_valid !== 1'b0) begin
      fails++; $display("FAIL R1: out_valid=%0b expected 0 after idle", out_valid);
    end

    // known digests, walked from the table (R2 R7 R8 R9)
    foreach (VECS[r]) begin
      checks++;
      if (ref_hash(VECS[r].cv, VECS[r].blk) !== VECS[r].dig) begin
        fails++;
        $display("FAIL R2: model=%h expected %h", ref_hash(VECS[r].cv, VECS[r].blk), VECS[r].dig);
      end
      push(1'b1, VECS[r].blk, VECS[r].cv, "R2 R7 R8 R9");
    end
    idle(LAT + 4, "R5");

    // R3: one lone chunk, exact arrival edge
    push(1'b1, rnd_blk(), IV, "R3");
    idle(LAT + 4, "R3");

    // R4: back-to-back chunks
    for (int k = 0; k < 8; k++) push(1'b1, rnd_blk(), IV, "R4");
    idle(2, "R4");

    // R5: bubbles carrying garbage on the data buses
    for (int k = 0; k < 6; k++) begin
      push(1'b1, rnd_blk(), IV, "R5");
      push(1'b0, rnd_blk(), rnd_cv(), "R5");
    end

    // R6: arbitrary chaining values
    for (int k = 0; k < 4; k++) push(1'b1, rnd_blk(), rnd_cv(), "R6");

    // R2 corners: all-zero and all-one operands
    push(1'b1, '0, '0, "R2");
    push(1'b1, '1, '1, "R2");
    idle(LAT + 4, "R5");
    finish_run();
  end

endmodule